// File: doc/BRIEF.md
# Memory Window Target Decoder

This block watches a shared multiplexed address/data bus and decides whether a transaction starting on it belongs to a 512 KB memory window. The window's upper address bits are set from outside through a base input. In the address phase it compares the upper address bits against that base and checks that the command is a memory command. On a match it claims the transaction and asserts device select with medium timing, on the second clock after the address phase. It also reports the dword offset of the access inside the window.

The two lowest address bits carry a burst-ordering code rather than address bits. Only linear incrementing is supported. Any other code raises an error flag and a disconnect request, so the target logic can end the burst after its first data phase. During a burst the offset advances by one dword for each completed data phase. Data movement and termination signalling belong to the surrounding target logic.

The block moves no data, so it has no valid/ready stream. All of its pins are plain bus-level control and status lines with no back-pressure.

Top module: `mbar_target_decode`

## Requirements
- R1: After reset, claim is 0, devsel_n is 1, order_err is 0 and disc_req is 0.
- R2: An address phase is a clock in which frame_n is low, frame_n was high in the previous clock, and irdy_n is high. Claim rises at the next clock only if both of these hold: ad[31:19] equals win_base, and cbe_n holds one of the memory commands 4'b0110, 4'b0111, 4'b1100, 4'b1110 or 4'b1111. Otherwise claim stays 0.
- R3: For a claimed transaction, devsel_n is still 1 on the first clock after the address phase. It goes to 0 on the second clock and stays at 0 until the transaction ends.
- R4: On a claim, dw_offset equals ad[18:2] from the address phase.
- R5: Every clock edge of a claimed transaction with devsel_n, irdy_n and trdy_n all low is a completed data phase. Each one adds one to dw_offset, modulo 2^17.
- R6: On a claim, order_err is 1 exactly when the address-phase ad[1:0] is not 2'b00. Code 2'b00 is linear, 2'b01 is cache-line toggle, and 2'b10 and 2'b11 are reserved.
- R7: disc_req is 1 while devsel_n is 0 and order_err is 1, and 0 otherwise.
- R8: A data phase that completes while frame_n is high ends the transaction. On the next clock, claim, order_err and disc_req are 0 and devsel_n is 1.
- R9: While frame_n stays low past the address phase, no new decode takes place, even if the bus carries a matching address and a memory command.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n | input | 1 | Transaction framing, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| trdy_n | input | 1 | Target ready from the target logic, active low |
| ad | input | 32 | Multiplexed address/data bus |
| cbe_n | input | 4 | Command during address phase, byte enables after |
| win_base | input | 13 | Programmed upper address bits of the window |
| claim | output | 1 | Transaction is owned by this window |
| devsel_n | output | 1 | Device select, medium timing, active low |
| dw_offset | output | 17 | Current dword offset inside the window |
| order_err | output | 1 | Non-linear burst ordering requested |
| disc_req | output | 1 | Request to disconnect after the first data phase |

## Verification
The assertions assume the bus follows a well-formed protocol. irdy_n stays high in the address phase, trdy_n is only driven low after device select, and frame_n goes high only together with or before the final data phase. The bench drives every transaction through a single task that sets frame_n, irdy_n and trdy_n in that order. The sweep covers all sixteen commands and all four ordering codes, with matching and non-matching addresses. Every data phase carries a matching address and a memory command, so a wrong re-decode in mid-burst would show up at the ports.

// File: rtl/mbar_pkg.sv
package mbar_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DECODE = 2'd1,
    ST_ACTIVE = 2'd2
  } tgt_state_e;

  typedef enum logic [1:0] {
    ORD_LINEAR = 2'b00,
    ORD_TOGGLE = 2'b01,
    ORD_RSV2   = 2'b10,
    ORD_RSV3   = 2'b11
  } burst_order_e;

  localparam logic [3:0] CMD_MEM_RD      = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR      = 4'b0111;
  localparam logic [3:0] CMD_MEM_RD_MULT = 4'b1100;
  localparam logic [3:0] CMD_MEM_RD_LINE = 4'b1110;
  localparam logic [3:0] CMD_MEM_WR_INV  = 4'b1111;

  function automatic logic is_mem_cmd(input logic [3:0] cmd);
    return (cmd == CMD_MEM_RD) || (cmd == CMD_MEM_WR) ||
           (cmd == CMD_MEM_RD_MULT) || (cmd == CMD_MEM_RD_LINE) ||
           (cmd == CMD_MEM_WR_INV);
  endfunction
endpackage

// File: rtl/mbar_addr_match.sv
module mbar_addr_match #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 19,
  localparam int BASE_W  = ADDR_W - WIN_LOG2
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic [3:0]        cmd,
  input  logic [BASE_W-1:0] base,
  output logic              hit
);
  import mbar_pkg::*;

  logic base_eq;
  logic cmd_ok;

  always_comb begin
    base_eq = (addr[ADDR_W-1:WIN_LOG2] == base);
    cmd_ok  = is_mem_cmd(cmd);
    hit     = base_eq && cmd_ok;
  end
endmodule

// File: rtl/mbar_order_check.sv
module mbar_order_check (
  input  logic [1:0] order_code,
  output logic       unsupported
);
  import mbar_pkg::*;

  burst_order_e ord;

  always_comb begin
    ord = burst_order_e'(order_code);
    unique case (ord)
      ORD_LINEAR: unsupported = 1'b0;
      ORD_TOGGLE: unsupported = 1'b1;
      ORD_RSV2:   unsupported = 1'b1;
      ORD_RSV3:   unsupported = 1'b1;
      default:    unsupported = 1'b1;
    endcase
  end
endmodule

// File: rtl/mbar_offset_ctr.sv
module mbar_offset_ctr #(
  parameter int OFF_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [OFF_W-1:0] load_val,
  input  logic             step,
  output logic [OFF_W-1:0] offset
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      offset <= '0;
    end else if (load) begin
      offset <= load_val;
    end else if (step) begin
      offset <= offset + OFF_W'(1);
    end
  end

  a_r5_step_one: assert property (@(posedge clk) disable iff (!rst_n)
    (step && !load) |=> (offset == $past(offset) + OFF_W'(1)));
endmodule

// File: rtl/mbar_target_decode.sv
module mbar_target_decode #(
  parameter int ADDR_W   = 32,
  parameter int WIN_LOG2 = 19,
  localparam int BASE_W  = ADDR_W - WIN_LOG2,
  localparam int OFF_W   = WIN_LOG2 - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_n,
  input  logic              irdy_n,
  input  logic              trdy_n,
  input  logic [ADDR_W-1:0] ad,
  input  logic [3:0]        cbe_n,
  input  logic [BASE_W-1:0] win_base,
  output logic              claim,
  output logic              devsel_n,
  output logic [OFF_W-1:0]  dw_offset,
  output logic              order_err,
  output logic              disc_req
);
  import mbar_pkg::*;

  tgt_state_e state_q;
  logic       frame_q;
  logic       hit;
  logic       ord_bad;
  logic       addr_phase;
  logic       start;
  logic       xfer;
  logic       err_q;

  mbar_addr_match #(.ADDR_W(ADDR_W), .WIN_LOG2(WIN_LOG2)) u_match (
    .addr (ad),
    .cmd  (cbe_n),
    .base (win_base),
    .hit  (hit)
  );

  mbar_order_check u_order (
    .order_code  (ad[1:0]),
    .unsupported (ord_bad)
  );

  always_comb begin
    addr_phase = frame_q && !frame_n && irdy_n;
    start      = (state_q == ST_IDLE) && addr_phase && hit;
    xfer       = (state_q == ST_ACTIVE) && !irdy_n && !trdy_n;
  end

  mbar_offset_ctr #(.OFF_W(OFF_W)) u_ctr (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (start),
    .load_val (ad[WIN_LOG2-1:2]),
    .step     (xfer),
    .offset   (dw_offset)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_q <= 1'b1;
      state_q <= ST_IDLE;
      err_q   <= 1'b0;
    end else begin
      frame_q <= frame_n;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q <= ST_DECODE;
            err_q   <= ord_bad;
          end
        end
        ST_DECODE: begin
          if (frame_n && irdy_n) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
          end else begin
            state_q <= ST_ACTIVE;
          end
        end
        ST_ACTIVE: begin
          if ((xfer && frame_n) || (frame_n && irdy_n)) begin
            state_q <= ST_IDLE;
            err_q   <= 1'b0;
          end
        end
        default: begin
          state_q <= ST_IDLE;
          err_q   <= 1'b0;
        end
      endcase
    end
  end

  always_comb begin
    claim     = (state_q != ST_IDLE);
    devsel_n  = (state_q != ST_ACTIVE);
    order_err = err_q;
    disc_req  = (state_q == ST_ACTIVE) && err_q;
  end

  a_r2_claim_needs_hit: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim) |-> $past(hit) && $past(addr_phase));

  a_r3_medium_select: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(devsel_n) |-> $past(claim) && $past(devsel_n));

  a_r3_select_inside_claim: assert property (@(posedge clk) disable iff (!rst_n)
    !devsel_n |-> claim);

  a_r6_order_flag: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(claim) |-> (order_err == ($past(ad[1:0]) != 2'b00)));

  a_r7_disc_gated: assert property (@(posedge clk) disable iff (!rst_n)
    disc_req |-> (order_err && !devsel_n));

  a_r8_end_release: assert property (@(posedge clk) disable iff (!rst_n)
    (!devsel_n && !irdy_n && !trdy_n && frame_n) |=> (!claim && devsel_n));
endmodule

// File: tb/mbar_target_decode_bench.sv
module mbar_target_decode_bench;
  localparam int CLK_PERIOD = 10;
  localparam logic [12:0] BASE = 13'h0A5B;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        frame_n = 1'b1;
  logic        irdy_n = 1'b1;
  logic        trdy_n = 1'b1;
  logic [31:0] ad = '0;
  logic [3:0]  cbe_n = '0;
  logic [12:0] win_base = BASE;
  logic        claim;
  logic        devsel_n;
  logic [16:0] dw_offset;
  logic        order_err;
  logic        disc_req;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  mbar_target_decode u_mbar_target_decode (
    .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
    .trdy_n(trdy_n), .ad(ad), .cbe_n(cbe_n), .win_base(win_base),
    .claim(claim), .devsel_n(devsel_n), .dw_offset(dw_offset),
    .order_err(order_err), .disc_req(disc_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit mem_cmd(input logic [3:0] c);
    return c == 4'b0110 || c == 4'b0111 || c == 4'b1100 || c == 4'b1110 || c == 4'b1111;
  endfunction

  // one transaction: address phase, then nph data phases
  task automatic run_txn(input logic [12:0] hi, input logic [16:0] off,
                         input logic [1:0] ord, input logic [3:0] cmd, input int nph);
    bit hit;
    bit err;
    hit = (hi == BASE) && mem_cmd(cmd);
    err = hit && (ord != 2'b00);
    @(negedge clk);
    frame_n = 1'b0; irdy_n = 1'b1; trdy_n = 1'b1;
    ad = {hi, off, ord}; cbe_n = cmd;
    @(negedge clk);
    chk("R2 claim", 32'(claim), 32'(hit));
    chk("R3 first clock", 32'(devsel_n), 32'd1);
    if (hit) begin
      chk("R4 offset", 32'(dw_offset), 32'(off));
      chk("R6 order_err", 32'(order_err), 32'(err));
    end
    // data phases carry a matching address and memory command (R9)
    ad = {BASE, 17'h00123, 2'b00}; cbe_n = 4'b0110;
    irdy_n = 1'b0; frame_n = (nph == 1);
    @(negedge clk);
    chk("R3 second clock", 32'(devsel_n), 32'(!hit));
    chk("R9 no redecode", 32'(claim), 32'(hit));
    chk("R7 disc_req", 32'(disc_req), 32'(err));
    for (int i = 0; i < nph; i++) begin
      trdy_n = hit ? 1'b0 : 1'b1;
      frame_n = (i == nph - 1);
      if (hit) chk("R5 offset step", 32'(dw_offset), 32'((off + 17'(i)) & 17'h1FFFF));
      @(negedge clk);
    end
    if (!hit) begin
      frame_n = 1'b1;
      @(negedge clk);
    end
    frame_n = 1'b1; irdy_n = 1'b1; trdy_n = 1'b1;
    chk("R8 claim released", 32'(claim), 32'd0);
    chk("R8 devsel released", 32'(devsel_n), 32'd1);
    chk("R8 flags cleared", 32'({order_err, disc_req}), 32'd0);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 2 + 1);
    chk("R1 claim", 32'(claim), 32'd0);
    chk("R1 devsel_n", 32'(devsel_n), 32'd1);
    chk("R1 flags", 32'({order_err, disc_req}), 32'd0);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 16; c++) begin
      for (int o = 0; o < 4; o++) begin
        logic [16:0] off;
        off = 17'((c * 4099 + o * 257) & 17'h1FFFF);
        run_txn(BASE, off, 2'(o), 4'(c), 1 + (c % 3));
        run_txn(BASE ^ 13'(1 << (c % 13)), off, 2'(o), 4'(c), 1 + (o % 2));
      end
    end
    // window edge: offset wraps
    run_txn(BASE, 17'h1FFFF, 2'b00, 4'b0111, 3);
    run_txn(BASE, 17'h1FFFE, 2'b00, 4'b1100, 4);
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule